// File: doc/BRIEF.md
# Supervisory I2C Target with Register and Converter Readback

This block is the bus-facing side of a supervisory chip. It watches the two-wire serial bus through oversampled, synchronised copies of SCL and SDA, answers to a 7-bit address, and serves three kinds of transfer. The address is the device-type nibble `1001` followed by three strap pins. The first kind is a register write: a command byte whose top bit is set picks a register, and each later byte is written to it. The second kind is a register read: the same command byte, a repeated START, and then a read burst. The third kind is a converter readback: a channel byte picks one of the sampled 10-bit conversion results, and a read after a repeated START returns that result packed with the channel number.

The host side is a plain register-file port. It has an address, write data, a one-cycle write strobe and read data that the host returns combinationally for the current address. The converter results are presented as static per-channel words. There is no valid/ready pair on either side. Without clock stretching the bus cannot be held, so the block applies no back-pressure, and the host must accept every write strobe in the cycle it is high. SDA is driven open-drain through a single "pull low" enable.

Top module: `i2cs_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `1001` followed by strap bits [2:0]. After a mismatch it leaves SDA released for every later bit until the next START or STOP.
- R2: An acknowledge pulls SDA low during the ninth SCL clock of the byte. SDA drive changes only while SCL is low.
- R3: A first data byte with bit 7 = 1 is a command byte and selects register index = bits [REG_AW-1:0]. Each further written byte produces one single-cycle write strobe for the current index, with that byte as data, and is acknowledged.
- R4: After a repeated START and an address with the read bit (bit 0 = 1), the block returns the register data of the current index MSB first. Each byte is loaded on the SCL falling edge that precedes its first bit.
- R5: Every completed read or write byte advances the register index by one, and the index wraps from 2^REG_AW-1 to 0.
- R6: A first data byte with bit 7 = 0 is a channel byte. When bits [6:4] are zero it is acknowledged and selects channel bits [3:0]. Otherwise it is not acknowledged and the previous channel is kept. Bytes written after a channel byte are not acknowledged and produce no write strobe.
- R7: In channel mode a read returns a byte pair. The first byte is {channel[3:0], sample[9:6]} and the second is {sample[5:0], 2'b00}. A third byte starts a new pair.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R9: A STOP or START detected at any point, including mid-byte, abandons the transfer: SDA is released and no write strobe results from a partial byte.
- R10: After reset SDA is released, the register index is 0 and channel 0 is selected in register mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Address strap pins |
| reg_addr_o | output | REG_AW | Current register index |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for reg_addr_o |
| adc_data_i | input | NCH*10 | Sampled conversion words, channel k at bits [10k+9:10k] |

## Verification
Two functions compete for the same cycle. The first is byte completion, together with its write strobe and index step. The second is the START/STOP abort path. The bench provokes this by ending a command's data byte after four bits with a STOP, then reads back to confirm that no strobe escaped and that the index still points at the commanded register. On the read side, the pair toggle and the loading of the next byte fall on one SCL falling edge. A three-byte converter read shows that the third byte restarts the pair, and a register burst across the last index shows that the wrap and the load agree.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int         ADC_W    = 10;
  localparam int         CH_W     = 4;
  localparam logic [3:0] DEV_TYPE = 4'b1001;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACKO, PH_TX, PH_ACKI, PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_DATA
  } kind_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
      q_d <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      q_d <= pipe[STAGES-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_adc_sel.sv
module i2cs_adc_sel import i2cs_pkg::*; #(
  parameter int NCH = 16
) (
  input  logic [NCH*ADC_W-1:0] adc_flat,
  input  logic [CH_W-1:0]      chan,
  output logic [ADC_W-1:0]     sample
);
  logic [NCH-1:0] hit;

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign hit[g] = (chan == CH_W'(g));
  end

  always_comb begin
    sample = '0;
    for (int i = 0; i < NCH; i++)
      if (hit[i]) sample = sample | adc_flat[i*ADC_W +: ADC_W];
  end
endmodule

// File: rtl/i2cs_target.sv
module i2cs_target import i2cs_pkg::*; #(
  parameter int REG_AW      = 4,
  parameter int NCH         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [2:0]           strap_i,
  output logic [REG_AW-1:0]    reg_addr_o,
  output logic [7:0]           reg_wdata_o,
  output logic                 reg_we_o,
  input  logic [7:0]           reg_rdata_i,
  input  logic [NCH*ADC_W-1:0] adc_data_i
);
  logic [1:0] lvl, lvl_d;
  logic scl_s, scl_rise, scl_fall, start_det, stop_det;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lvl), .q_d(lvl_d)
  );

  assign scl_s     = lvl[1];
  assign scl_rise  = lvl[1] & ~lvl_d[1];
  assign scl_fall  = ~lvl[1] & lvl_d[1];
  assign start_det = lvl[1] & lvl_d[1] & lvl_d[0] & ~lvl[0];
  assign stop_det  = lvl[1] & lvl_d[1] & ~lvl_d[0] & lvl[0];

  phase_t            ph;
  kind_t             kind;
  logic [3:0]        cnt;
  logic [7:0]        sh, tx, nxt;
  logic [REG_AW-1:0] ptr;
  logic [CH_W-1:0]   chan;
  logic [7:0]        adc_lo;
  logic [ADC_W-1:0]  smp;
  logic mode_adc, half, rd_go, mack, addr_hit;

  i2cs_adc_sel #(.NCH(NCH)) u_adc (.adc_flat(adc_data_i), .chan(chan), .sample(smp));

  assign addr_hit   = (sh[7:1] == {DEV_TYPE, strap_i});
  assign reg_addr_o = ptr;

  always_comb begin
    if (mode_adc) nxt = half ? adc_lo : {chan, smp[ADC_W-1 -: 4]};
    else          nxt = reg_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; kind <= K_ADDR; cnt <= '0; sh <= '0; tx <= '0;
      ptr <= '0; chan <= '0; adc_lo <= '0; mode_adc <= 1'b0; half <= 1'b0;
      rd_go <= 1'b0; mack <= 1'b0; sda_oe_o <= 1'b0;
      reg_we_o <= 1'b0; reg_wdata_o <= '0;
    end else begin
      if (reg_we_o) begin
        reg_we_o <= 1'b0;
        ptr      <= ptr + 1'b1;
      end
      if (stop_det) begin
        ph <= PH_IDLE; sda_oe_o <= 1'b0;
      end else if (start_det) begin
        ph <= PH_RX; kind <= K_ADDR; cnt <= '0; sda_oe_o <= 1'b0;
      end else begin
        unique case (ph)
          PH_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], lvl[0]};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              unique case (kind)
                K_ADDR: begin
                  if (addr_hit) begin
                    sda_oe_o <= 1'b1; ph <= PH_ACKO; rd_go <= sh[0];
                    kind <= K_CMD; half <= 1'b0;
                  end else begin
                    ph <= PH_SKIP;
                  end
                end
                K_CMD: begin
                  kind <= K_DATA; ph <= PH_ACKO; rd_go <= 1'b0;
                  if (sh[7]) begin
                    mode_adc <= 1'b0; ptr <= sh[REG_AW-1:0]; sda_oe_o <= 1'b1;
                  end else if (sh[6:4] == 3'b000) begin
                    mode_adc <= 1'b1; chan <= sh[CH_W-1:0]; sda_oe_o <= 1'b1;
                  end
                end
                default: begin
                  ph <= PH_ACKO; rd_go <= 1'b0;
                  if (!mode_adc) begin
                    sda_oe_o <= 1'b1; reg_we_o <= 1'b1; reg_wdata_o <= sh;
                  end
                end
              endcase
            end
          end
          PH_ACKO: begin
            if (scl_fall) begin
              if (rd_go) begin
                tx <= nxt; sda_oe_o <= ~nxt[7]; cnt <= '0; ph <= PH_TX;
                if (mode_adc && !half) adc_lo <= {smp[5:0], 2'b00};
              end else begin
                sda_oe_o <= 1'b0; ph <= PH_RX; cnt <= '0;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe_o <= 1'b0; ph <= PH_ACKI; half <= ~half; mack <= 1'b0;
                if (!mode_adc) ptr <= ptr + 1'b1;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe_o <= ~tx[6]; cnt <= cnt + 1'b1;
              end
            end
          end
          PH_ACKI: begin
            if (scl_rise) begin
              mack <= ~lvl[0];
            end else if (scl_fall) begin
              if (mack) begin
                tx <= nxt; sda_oe_o <= ~nxt[7]; cnt <= '0; ph <= PH_TX;
                if (mode_adc && !half) adc_lo <= {smp[5:0], 2'b00};
              end else begin
                ph <= PH_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);
  assert_index_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> reg_addr_o == REG_AW'($past(reg_addr_o) + 1'b1));
  assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s);
  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe_o);
  assert_no_write_in_chan_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> !mode_adc);
  assert_skip_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SKIP) |=> !sda_oe_o);
endmodule

// File: tb/tb_i2cs_target.sv
module tb_i2cs_target;
  localparam int CLK_P  = 10;
  localparam int Q      = 5 * CLK_P;
  localparam int REG_AW = 4;
  localparam int NCH    = 16;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line, reg_we, quiet = 1'b0;
  logic [2:0] strap = 3'b101;
  logic [REG_AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [2**REG_AW];
  logic [NCH*10-1:0] adc;
  logic [11:0] wq [$];
  int nchk = 0, nfail = 0;

  always #(CLK_P/2) clk = ~clk;
  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2cs_target #(.REG_AW(REG_AW), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata), .adc_data_i(adc)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 7 + 1);
  endfunction
  function automatic logic [9:0] adc_val(int k);
    return 10'((k * 61 + 3) % 1024);
  endfunction

  always @(posedge clk)
    if (!rst_n) for (int i = 0; i < 2**REG_AW; i++) mem[i] <= init_val(i);
    else if (reg_we) mem[reg_addr] <= reg_wdata;

  initial for (int k = 0; k < NCH; k++) adc[k*10 +: 10] = adc_val(k);

  task automatic chk(string rq, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // per-clock model comparison: write strobes against the expected queue, quiet line
  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin
      if (wq.size() == 0) chk("R3/R6 unexpected write", {reg_addr, reg_wdata}, 0);
      else chk("R3 write addr/data", {reg_addr, reg_wdata}, wq.pop_front());
    end
    if (quiet) chk("R1 released", sda_oe, 0);
  end

  task automatic bit_out(logic b);
    scl = 1'b0; #Q; sda_m = b; #Q; scl = 1'b1; #Q; #Q;
  endtask
  task automatic bit_in(output logic r);
    scl = 1'b0; #Q; sda_m = 1'b1; #Q; scl = 1'b1; #Q; r = sda_line; #Q;
  endtask
  task automatic start_c();
    scl = 1'b0; #Q; sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q;
  endtask
  task automatic stop_c();
    scl = 1'b0; #Q; sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask
  task automatic send(logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(r);
    ack = ~r;
  endtask
  task automatic recv(output logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(~ack);
  endtask

  logic [7:0] hi3, lo3;
  assign hi3 = {4'd3, adc_val(3)[9:6]};
  assign lo3 = {adc_val(3)[5:0], 2'b00};

  initial begin
    logic a;
    logic [7:0] b;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 sda released", sda_oe, 0);
    chk("R10 index zero", reg_addr, 0);

    quiet = 1'b1;
    start_c(); send(8'h96, a); chk("R1 wrong address nack", a, 0);
    send(8'h00, a); chk("R1 ignored byte", a, 0);
    stop_c(); quiet = 1'b0;

    wq.push_back({4'd5, 8'hA5}); wq.push_back({4'd6, 8'h3C});
    start_c(); send(8'h9A, a); chk("R1 address ack", a, 1);
    send(8'h85, a); chk("R3 command ack", a, 1);
    send(8'hA5, a); chk("R3 data ack", a, 1);
    send(8'h3C, a); chk("R3 second data ack", a, 1);
    stop_c(); chk("R3 all writes seen", wq.size(), 0);

    start_c(); send(8'h9A, a); send(8'h8E, a);
    start_c(); send(8'h9B, a); chk("R2 read address ack", a, 1);
    recv(b, 1); chk("R4 burst byte 14", b, init_val(14));
    recv(b, 1); chk("R5 burst byte 15", b, init_val(15));
    recv(b, 0); chk("R5 wrap to 0", b, init_val(0));
    #(4*CLK_P); chk("R8 released after nack", sda_oe, 0);
    stop_c();

    start_c(); send(8'h9A, a); send(8'h85, a);
    start_c(); send(8'h9B, a); recv(b, 0); chk("R4 readback reg 5", b, 8'hA5);
    stop_c();

    start_c(); send(8'h9A, a); send(8'h03, a); chk("R6 channel ack", a, 1);
    start_c(); send(8'h9B, a);
    recv(b, 1); chk("R7 first pair byte", b, hi3);
    recv(b, 1); chk("R7 second pair byte", b, lo3);
    recv(b, 0); chk("R7 pair restarts", b, hi3);
    stop_c();

    start_c(); send(8'h9A, a); send(8'h23, a); chk("R6 bad channel nack", a, 0);
    stop_c();
    start_c(); send(8'h9B, a); recv(b, 0); chk("R6 channel kept", b, hi3);
    stop_c();

    start_c(); send(8'h9A, a); send(8'h07, a);
    send(8'h55, a); chk("R6 data after channel nack", a, 0);
    stop_c();

    start_c(); send(8'h9A, a); send(8'h81, a);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    stop_c(); #(4*CLK_P); chk("R9 released after abort", sda_oe, 0);
    start_c(); send(8'h9B, a); recv(b, 0); chk("R9 index kept after abort", b, init_val(1));
    stop_c();

    repeat (20) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule